// File: doc/BRIEF.md
# Parallel EEPROM Page Write Controller

This block is a host-side bus master that programs a run of bytes into a byte-wide parallel EEPROM. A command gives a start address and a byte count. The bytes then arrive on a valid/ready stream. Each byte goes out as a write-enable-controlled strobe cycle on the memory pins. The address rises by one per byte. Every byte of a command must sit inside one page, so that the memory programs them all in a single internal cycle.

Once the last byte is out, the controller releases the data bus. It then polls the memory with read cycles and watches the toggle bit. The memory is still busy while that bit differs between two successive reads. When two successive reads agree, programming has finished and `done_o` pulses. Three faults end a transaction with an `err_o` pulse: a command that would cross a page, a byte stream that stalls past the load window, and a poll count that reaches its limit.

All strobe widths, setup gaps, the load window and the poll limit are parameters in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, and whenever no transaction is active, `mem_ce_no`, `mem_oe_no` and `mem_we_no` are all 1 and `mem_dq_oe_o` is 0. In this state `cmd_ready_o` is 1 and `byte_ready_o` is 0.
- R2: A command is rejected when its length is 0, or when the low `PAGE_W` address bits plus the length exceed 2^`PAGE_W`, so that bits 12..5 would differ. A rejected command gives exactly one `err_o` pulse, drives no strobe, and leaves the block idle.
- R3: `cmd_ready_o` is 0 throughout an accepted transaction. `byte_ready_o` is 1 only while chip enable is low and the controller waits for the next byte.
- R4: Each byte is driven on `mem_dq_o` with `mem_dq_oe_o`=1 for `SETUP_CYC` cycles. Then `mem_we_no` is low for exactly `WE_LOW_CYC` cycles, with `mem_ce_no`=0, `mem_oe_no`=1 and the data held stable.
- R5: Between two write pulses of one transaction, `mem_we_no` stays high for at least `WE_HIGH_CYC` cycles. Byte i of the stream is written at start address + i.
- R6: If the controller waits `LOAD_WIN_CYC` cycles for a byte and none arrives, it pulses `err_o` and returns to idle. The bytes already sent stay sent, and no poll reads are made.
- R7: `mem_dq_oe_o` is 0 during every cycle that `mem_oe_no` is low, and also during the cycle before each fall of `mem_oe_no`. The first poll read starts no sooner than `OE_GAP_CYC`+1 cycles after the last write strobe rises.
- R8: Each poll read holds `mem_oe_no` low for `READ_CYC` cycles, with one high cycle between reads. `done_o` pulses after the first read whose bit `TOG_BIT` (bit 6) equals that of the read before it.
- R9: If `POLL_MAX` reads pass without two successive equal toggle bits, `err_o` pulses and the block returns to idle.
- R10: Each transaction ends with exactly one single-cycle pulse on either `done_o` or `err_o`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_addr_i | input | ADDR_W | Start address |
| cmd_len_i | input | PAGE_W+1 | Byte count, 1 to 2^PAGE_W |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Stream byte accepted when high with valid |
| byte_data_i | input | DATA_W | Stream byte |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data driven to the memory |
| mem_dq_oe_o | output | 1 | Host drives the data bus when 1 |
| mem_dq_i | input | DATA_W | Data read from the memory |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| done_o | output | 1 | Programming finished pulse |
| err_o | output | 1 | Reject, stall or poll timeout pulse |

## Verification
The bench sweeps start offsets across the page against every length from 0 to 32. A design that gets the page-span arithmetic wrong by one either writes a byte into the next page or rejects a full page that ends exactly on the boundary. A memory model toggles the status bit for a set number of reads. The cases are placed so that success lands exactly on the poll limit and a timeout lands one read past it; an off-by-one counter reports done where it should time out, or the reverse. Stalled streams, including a stall before the first byte, check that the load window aborts without any poll reads. The model flags any cycle where output enable falls while the host still drives the bus, and any write pulse whose width is not exact.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETUP, S_WE_LO, S_WE_HI, S_GAP, S_RD, S_RHI
  } eepw_state_e;
endpackage

// File: rtl/eepw_timer.sv
module eepw_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eepw_span_chk.sv
module eepw_span_chk #(
  parameter int PAGE_W = 5
) (
  input  logic [PAGE_W-1:0] off_i,
  input  logic [PAGE_W:0]   len_i,
  output logic              bad_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  logic [PAGE_W+1:0] end_w;
  always_comb begin
    end_w = {2'b00, off_i} + {1'b0, len_i};
    bad_o = (len_i == '0) || (end_w > (PAGE_W+2)'(PAGE_BYTES));
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 5,
  parameter int SETUP_CYC    = 2,
  parameter int WE_LOW_CYC   = 20,
  parameter int WE_HIGH_CYC  = 26,
  parameter int OE_GAP_CYC   = 2,
  parameter int READ_CYC     = 20,
  parameter int LOAD_WIN_CYC = 6250,
  parameter int POLL_MAX     = 65535,
  parameter int TOG_BIT      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [PAGE_W:0]   cmd_len_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [DATA_W-1:0] byte_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              done_o,
  output logic              err_o
);
  localparam int M1 = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int M2 = (WE_HIGH_CYC > OE_GAP_CYC) ? WE_HIGH_CYC : OE_GAP_CYC;
  localparam int M3 = (READ_CYC > LOAD_WIN_CYC) ? READ_CYC : LOAD_WIN_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M12 > M3) ? M12 : M3;
  localparam int TW = $clog2(T_MAX + 1);
  localparam int PC_W = $clog2(POLL_MAX + 1);

  eepw_state_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W:0]   left_q;
  logic [DATA_W-1:0] data_q;
  logic [PC_W-1:0]   poll_q;
  logic              prev_q, have_prev_q;
  logic              done_q, err_q;
  logic              t_load, t_zero;
  logic [TW-1:0]     t_val;
  logic              span_bad;
  logic              rd_bit, rd_match, rd_limit;

  eepw_span_chk #(.PAGE_W(PAGE_W)) u_span (
    .off_i (cmd_addr_i[PAGE_W-1:0]),
    .len_i (cmd_len_i),
    .bad_o (span_bad)
  );

  eepw_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  assign rd_bit   = mem_dq_i[TOG_BIT];
  assign rd_match = have_prev_q && (rd_bit == prev_q);
  assign rd_limit = (poll_q + 1'b1) == PC_W'(POLL_MAX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (cmd_valid_i && !span_bad) st_d = S_LOAD;
      S_LOAD:  if (byte_valid_i) st_d = S_SETUP;
               else if (t_zero) st_d = S_IDLE;
      S_SETUP: if (t_zero) st_d = S_WE_LO;
      S_WE_LO: if (t_zero) st_d = S_WE_HI;
      S_WE_HI: if (t_zero) st_d = (left_q == 1) ? S_GAP : S_LOAD;
      S_GAP:   if (t_zero) st_d = S_RD;
      S_RD:    if (t_zero) st_d = (rd_match || rd_limit) ? S_IDLE : S_RHI;
      S_RHI:   if (t_zero) st_d = S_RD;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    t_load = (st_d != st_q);
    unique case (st_d)
      S_LOAD:  t_val = TW'(LOAD_WIN_CYC - 1);
      S_SETUP: t_val = TW'(SETUP_CYC - 1);
      S_WE_LO: t_val = TW'(WE_LOW_CYC - 1);
      S_WE_HI: t_val = TW'(WE_HIGH_CYC - 1);
      S_GAP:   t_val = TW'(OE_GAP_CYC - 1);
      S_RD:    t_val = TW'(READ_CYC - 1);
      default: t_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      data_q      <= '0;
      poll_q      <= '0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          if (span_bad) err_q <= 1'b1;
          else begin
            addr_q <= cmd_addr_i;
            left_q <= cmd_len_i;
          end
        end
        S_LOAD: begin
          if (byte_valid_i) data_q <= byte_data_i;
          else if (t_zero)  err_q  <= 1'b1;
        end
        S_WE_HI: if (t_zero) begin
          if (left_q == 1) begin
            poll_q      <= '0;
            have_prev_q <= 1'b0;
          end else begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + 1'b1;
          end
        end
        S_RD: if (t_zero) begin
          if (rd_match)      done_q <= 1'b1;
          else if (rd_limit) err_q  <= 1'b1;
          else begin
            prev_q      <= rd_bit;
            have_prev_q <= 1'b1;
            poll_q      <= poll_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cmd_ready_o  = (st_q == S_IDLE);
  assign byte_ready_o = (st_q == S_LOAD);
  assign mem_addr_o   = addr_q;
  assign mem_dq_o     = data_q;
  assign mem_dq_oe_o  = (st_q == S_SETUP) || (st_q == S_WE_LO) || (st_q == S_WE_HI);
  assign mem_ce_no    = (st_q == S_IDLE);
  assign mem_we_no    = (st_q != S_WE_LO);
  assign mem_oe_no    = (st_q != S_RD);
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 5,
  parameter int WE_LOW_CYC = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              byte_ready_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              done_o,
  input logic              err_o
);
  logic [15:0] lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lo_cnt <= '0;
    else if (!mem_we_no) lo_cnt <= (lo_cnt == 16'hffff) ? lo_cnt : lo_cnt + 1'b1;
    else                 lo_cnt <= '0;
  end

  p_idle_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (mem_we_no && mem_oe_no && !mem_dq_oe_o));
  p_busy_no_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !cmd_ready_o);
  p_byte_rdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (!mem_ce_no && mem_we_no && mem_oe_no));
  p_we_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (lo_cnt == WE_LOW_CYC));
  p_we_oe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && mem_dq_oe_o && !mem_ce_no));
  p_we_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> ($stable(mem_dq_o) && $stable(mem_addr_o)));
  p_page_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o[ADDR_W-1:PAGE_W]));
  p_no_contention_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  p_release_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> $past(!mem_dq_oe_o));
  p_end_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind eeprom_page_writer eepw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WE_LOW_CYC(WE_LOW_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .byte_ready_o(byte_ready_o),
  .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
  .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int SETUP = 1, WE_LOW = 3, WE_HIGH = 4, OE_GAP = 2, RDC = 2;
  localparam int WIN = 16, PMAX = 8;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [12:0] cmd_addr = '0;
  logic [5:0]  cmd_len = '0;
  logic byte_valid, byte_ready;
  logic [7:0] byte_data;
  logic [12:0] m_addr;
  logic [7:0] m_dq, m_dq_in;
  logic m_oe, m_ce_n, m_oe_n, m_we_n, done, err;

  always #4 clk = ~clk;

  eeprom_page_writer #(
    .SETUP_CYC(SETUP), .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HIGH), .OE_GAP_CYC(OE_GAP),
    .READ_CYC(RDC), .LOAD_WIN_CYC(WIN), .POLL_MAX(PMAX)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .byte_valid_i(byte_valid),
    .byte_ready_o(byte_ready), .byte_data_i(byte_data), .mem_addr_o(m_addr),
    .mem_dq_o(m_dq), .mem_dq_oe_o(m_oe), .mem_dq_i(m_dq_in), .mem_ce_no(m_ce_n),
    .mem_oe_no(m_oe_n), .mem_we_no(m_we_n), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 7 + i * 29 + 8'h5A) & 8'hff);
  endfunction

  // stream feeder
  logic feed_clr = 0;
  int feed_len = 0, feed_hold = -1, feed_seed = 0;
  int idx = 0;
  bit acc_pend = 0;
  always @(negedge clk) begin
    if (feed_clr) begin idx = 0; acc_pend = 0; end
    else if (acc_pend) idx++;
    byte_data  = pat(feed_seed, idx);
    byte_valid = !feed_clr && (idx < feed_len) && (idx != feed_hold);
    acc_pend   = byte_valid && byte_ready;
  end

  // memory model
  logic model_clr = 0;
  int busy_cfg = 0, busy_left = 0;
  logic tog = 0;
  int ncap = 0, nrd = 0, lo_run = 0, hi_run = 0;
  int bad_we = 0, bad_gap = 0, bad_bus = 0, bad_hs = 0;
  logic [12:0] cap_a [0:31];
  logic [7:0]  cap_d [0:31];
  logic p_we = 1, p_oe = 1, p_doe = 0;
  assign m_dq_in = {1'b0, tog, 6'b0};

  always @(negedge clk) begin
    if (model_clr) begin
      ncap = 0; nrd = 0; tog = 0; busy_left = busy_cfg; lo_run = 0; hi_run = 0;
      bad_we = 0; bad_gap = 0; bad_bus = 0; bad_hs = 0;
    end else begin
      if (!m_we_n) begin
        lo_run++;
        if (!m_oe_n || m_ce_n || !m_oe) bad_we++;
      end
      if (m_we_n && !p_we) begin
        if (ncap < 32) begin cap_a[ncap] = m_addr; cap_d[ncap] = m_dq; end
        ncap++;
        if (lo_run != WE_LOW) bad_we++;
        lo_run = 0; hi_run = 0;
      end
      if (!m_we_n && p_we && ncap > 0 && hi_run < WE_HIGH) bad_gap++;
      if (m_we_n) hi_run++;
      if (!m_oe_n && (m_oe || p_doe)) bad_bus++;
      if (!m_oe_n && p_oe) begin
        nrd++;
        if (nrd == 1 && hi_run < OE_GAP + 1) bad_bus++;
      end
      if (m_oe_n && !p_oe && busy_left > 0) begin tog = ~tog; busy_left--; end
      if (cmd_ready && !m_ce_n) bad_hs++;
      if (byte_ready && m_ce_n) bad_hs++;
    end
    p_we = m_we_n; p_oe = m_oe_n; p_doe = m_oe;
  end

  // one transaction; hold = stream index that never arrives (-1 none)
  task automatic run_tx(input int addr, input int len, input int busy, input int hold);
    int off, ndone, nerr, seen, exp_rd;
    bit reject, stall, exp_done;
    off = addr & 31;
    reject = (len == 0) || (off + len > 32);
    stall = !reject && hold >= 0 && hold < len;
    exp_done = !reject && !stall && (busy + 2 <= PMAX);
    exp_rd = (reject || stall) ? 0 : ((busy + 2 <= PMAX) ? busy + 2 : PMAX);
    @(negedge clk); #1;
    model_clr = 1; feed_clr = 1; busy_cfg = busy;
    feed_len = len; feed_hold = hold; feed_seed = addr;
    @(negedge clk); #1;
    model_clr = 0; feed_clr = 0;
    cmd_addr = 13'(addr); cmd_len = 6'(len); cmd_valid = 1;
    ndone = 0; nerr = 0; seen = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (t == 0) #1 cmd_valid = 0;
      ndone += int'(done); nerr += int'(err);
      if (done || err) seen++;
      else if (seen > 0) seen++;
      if (seen > 3) break;
    end
    if (reject) begin
      check(nerr == 1 && ndone == 0, "R2 reject err", nerr, 1);
      check(ncap == 0, "R2 no writes", ncap, 0);
    end else if (stall) begin
      check(nerr == 1 && ndone == 0, "R6 stall err", nerr, 1);
      check(ncap == hold, "R6 bytes before stall", ncap, hold);
      check(nrd == 0, "R6 no polling", nrd, 0);
    end else begin
      bit ok = (ncap == len);
      for (int i = 0; i < len && i < 32; i++)
        if (cap_a[i] != 13'(addr + i) || cap_d[i] != pat(addr, i)) ok = 0;
      check(ok, "R5 address/data sequence", ncap, len);
      check(nrd == exp_rd, exp_done ? "R8 poll reads" : "R9 poll reads", nrd, exp_rd);
      if (exp_done) check(ndone == 1 && nerr == 0, "R8 done", ndone, 1);
      else          check(nerr == 1 && ndone == 0, "R9 timeout err", nerr, 1);
    end
    check(ndone + nerr == 1, "R10 single end pulse", ndone + nerr, 1);
    check(bad_we == 0, "R4 write strobe", bad_we, 0);
    check(bad_gap == 0, "R5 we high gap", bad_gap, 0);
    check(bad_bus == 0, "R7 bus release", bad_bus, 0);
    check(bad_hs == 0, "R3 handshake", bad_hs, 0);
    check(cmd_ready && m_ce_n && m_we_n && m_oe_n && !m_oe, "R1 back idle",
          {cmd_ready, m_ce_n, m_we_n, m_oe_n, m_oe}, 5'b11110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready && !byte_ready && m_ce_n && m_we_n && m_oe_n && !m_oe && !done && !err,
          "R1 reset state", {cmd_ready, byte_ready, m_ce_n, m_we_n, m_oe_n, m_oe}, 6'b101110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int off = 0; off < 32; off += 5)
      for (int len = 0; len <= 32; len++)
        run_tx(((off * 3 + len) & 255) * 32 + off, len, len % 5, -1);
    run_tx(13'h1fe0, 32, 1, -1);
    run_tx(13'h0040, 4, PMAX - 2, -1);
    run_tx(13'h0080, 4, PMAX - 1, -1);
    run_tx(13'h0103, 8, 0, 3);
    run_tx(13'h0200, 5, 0, 0);
    run_tx(13'h031f, 2, 0, -1);
    summary();
  end
endmodule